// File: doc/BRIEF.md
# Packed SIMD Sign-Apply Unit

This datapath block takes two packed 256-bit vectors, a value operand (`dest`) and a sign-control operand (`ctrl`), and forms a packed result one lane at a time. For each lane it reads the control lane as a signed integer. A negative control lane negates the value lane. A zero control lane forces the result lane to zero. A positive control lane passes the value lane through unchanged. The lane width is chosen per operation: bytes, 16-bit halves or 32-bit words.

A two-bit mode chooses how much of the vector is computed and how the bits above it are formed:
- 64-bit mode and legacy 128-bit mode keep the untouched upper bits from a supplied previous-contents vector.
- The 128-bit clearing mode zeroes bits 255:128.
- 256-bit mode computes every lane.

A separate wide-length flag that is set in any mode other than the 256-bit mode is an illegal combination. The unit reports it and leaves the result register unwritten. The operands are sampled when `in_valid` is high, and all outputs are registered one clock later.

Top module: `sgn_apply_top`

## Requirements
- R1: When a control lane has its top bit set, the result lane is the two's-complement negation of the value lane, taken modulo the lane width. The most negative value (for example 0x80 in byte lanes, 0x80000000 in word lanes) maps to itself, with no saturation and no flag.
- R2: When a control lane is all zeros, the result lane is zero, whatever the value lane holds.
- R3: When a control lane is non-zero and its top bit is clear, the result lane equals the value lane.
- R4: `esize` selects the lane width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Each lane is handled independently of its neighbours.
- R5: With `mode` = 0 (64-bit), result bits 63:0 are computed and result bits 255:64 are copied from `prev_dest`.
- R6: With `mode` = 1 (legacy 128-bit), result bits 127:0 are computed and result bits 255:128 are copied from `prev_dest`.
- R7: With `mode` = 2 (clearing 128-bit), result bits 127:0 are computed and result bits 255:128 are zero.
- R8: With `mode` = 3 (256-bit), all 256 result bits are computed lane by lane.
- R9: An accepted operation with `len_wide` = 1 and `mode` other than 3 raises `ud_err` together with `out_valid`, and `result` keeps its previous value. With `mode` = 3, `len_wide` has no effect.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `ud_err` is low whenever `out_valid` is low. `result` does not change after a cycle with `in_valid` low.
- R11: After synchronous reset, `out_valid`, `ud_err` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| mode | input | 2 | 0: 64-bit, 1: 128-bit keep upper, 2: 128-bit clear upper, 3: 256-bit |
| esize | input | 2 | Lane width select: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 give 32 bits |
| len_wide | input | 1 | Wide vector-length flag; illegal unless mode is 3 |
| dest | input | 256 | Value operand |
| ctrl | input | 256 | Sign-control operand |
| prev_dest | input | 256 | Previous destination contents for the preserved upper bits |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 256 | Registered packed result |
| ud_err | output | 1 | Illegal mode and length combination reported |

## Verification
The hardest cases to reach from the ports are wide control lanes that are exactly zero and value lanes that hold the most negative number. Uniformly random 16-bit or 32-bit control lanes almost never produce either. The stimulus therefore builds each control word from biased pieces: whole zero words, and bytes of 0x00, 0x80 or 0xFF. Value operands are seeded with minimum-value patterns in the same way. Directed steps cover the rest:
- the illegal length flag, where the previously held result must stay unchanged;
- idle cycles, which must not disturb the held result.

// File: rtl/sgn_pkg.sv
package sgn_pkg;

  typedef enum logic [1:0] {
    MODE_N64   = 2'd0,
    MODE_K128  = 2'd1,
    MODE_C128  = 2'd2,
    MODE_F256  = 2'd3
  } sgn_mode_e;

  typedef enum logic [1:0] {
    LANE_B8    = 2'd0,
    LANE_H16   = 2'd1,
    LANE_W32   = 2'd2,
    LANE_W32X  = 2'd3
  } lane_sz_e;

  localparam int NARROW_BITS = 64;
  localparam int MID_BITS    = 128;

endpackage

// File: rtl/sgn_lane.sv
module sgn_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] val,
  input  logic [LW-1:0] sel,
  output logic [LW-1:0] res
);
  always_comb begin
    if (sel[LW-1])
      res = ~val + 1'b1;
    else if (sel == '0)
      res = '0;
    else
      res = val;
  end
endmodule

// File: rtl/sgn_slice.sv
module sgn_slice
  import sgn_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic [SW-1:0] val,
  input  logic [SW-1:0] sel,
  input  lane_sz_e      sz,
  output logic [SW-1:0] res
);
  localparam int NB = SW / 8;
  localparam int NH = SW / 16;
  localparam int NW = SW / 32;

  logic [SW-1:0] r8, r16, r32;

  for (genvar b = 0; b < NB; b++) begin : g_b8
    sgn_lane #(.LW(8)) u_lane (
      .val(val[b*8 +: 8]), .sel(sel[b*8 +: 8]), .res(r8[b*8 +: 8]));
  end

  for (genvar h = 0; h < NH; h++) begin : g_h16
    sgn_lane #(.LW(16)) u_lane (
      .val(val[h*16 +: 16]), .sel(sel[h*16 +: 16]), .res(r16[h*16 +: 16]));
  end

  for (genvar w = 0; w < NW; w++) begin : g_w32
    sgn_lane #(.LW(32)) u_lane (
      .val(val[w*32 +: 32]), .sel(sel[w*32 +: 32]), .res(r32[w*32 +: 32]));
  end

  always_comb begin
    case (sz)
      LANE_B8:  res = r8;
      LANE_H16: res = r16;
      default:  res = r32;
    endcase
  end
endmodule

// File: rtl/sgn_upper_sel.sv
module sgn_upper_sel
  import sgn_pkg::*;
#(
  parameter int VEC_W = 256,
  parameter int SW    = 32
) (
  input  logic [VEC_W-1:0] calc,
  input  logic [VEC_W-1:0] prev,
  input  sgn_mode_e        mode,
  output logic [VEC_W-1:0] merged
);
  localparam int NSL = VEC_W / SW;

  for (genvar s = 0; s < NSL; s++) begin : g_sl
    localparam int LO = s * SW;
    localparam bit ABOVE64  = (LO >= NARROW_BITS);
    localparam bit ABOVE128 = (LO >= MID_BITS);
    always_comb begin
      merged[LO +: SW] = calc[LO +: SW];
      case (mode)
        MODE_N64:  if (ABOVE64)  merged[LO +: SW] = prev[LO +: SW];
        MODE_K128: if (ABOVE128) merged[LO +: SW] = prev[LO +: SW];
        MODE_C128: if (ABOVE128) merged[LO +: SW] = '0;
        default:   merged[LO +: SW] = calc[LO +: SW];
      endcase
    end
  end
endmodule

// File: rtl/sgn_apply_top.sv
module sgn_apply_top
  import sgn_pkg::*;
#(
  parameter int VEC_W = 256,
  parameter int SW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [1:0]       esize,
  input  logic             len_wide,
  input  logic [VEC_W-1:0] dest,
  input  logic [VEC_W-1:0] ctrl,
  input  logic [VEC_W-1:0] prev_dest,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             ud_err
);
  localparam int NSL = VEC_W / SW;

  sgn_mode_e        mode_e;
  lane_sz_e         sz_e;
  logic [VEC_W-1:0] calc;
  logic [VEC_W-1:0] merged;
  logic             illegal;

  assign mode_e  = sgn_mode_e'(mode);
  assign sz_e    = lane_sz_e'(esize);
  assign illegal = len_wide && (mode_e != MODE_F256);

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    sgn_slice #(.SW(SW)) u_slice (
      .val(dest[s*SW +: SW]),
      .sel(ctrl[s*SW +: SW]),
      .sz (sz_e),
      .res(calc[s*SW +: SW])
    );
  end

  sgn_upper_sel #(.VEC_W(VEC_W), .SW(SW)) u_upper (
    .calc  (calc),
    .prev  (prev_dest),
    .mode  (mode_e),
    .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ud_err    <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      ud_err    <= in_valid && illegal;
      if (in_valid && !illegal)
        result <= merged;
    end
  end
endmodule

// File: rtl/sgn_apply_chk.sv
module sgn_apply_chk #(
  parameter int VEC_W = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       mode,
  input logic [1:0]       esize,
  input logic             len_wide,
  input logic [VEC_W-1:0] dest,
  input logic [VEC_W-1:0] ctrl,
  input logic [VEC_W-1:0] prev_dest,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             ud_err
);
  logic legal;
  assign legal = !len_wide || (mode == 2'd3);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));
  assert_err_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    ud_err |-> out_valid);
  assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal) |=> (ud_err && $stable(result)));
  assert_legal_no_err_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal) |=> !ud_err);
  assert_keep64_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && mode == 2'd0) |=>
      result[VEC_W-1:64] == $past(prev_dest[VEC_W-1:64]));
  assert_keep128_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && mode == 2'd1) |=>
      result[VEC_W-1:128] == $past(prev_dest[VEC_W-1:128]));
  assert_clear128_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && mode == 2'd2) |=> result[VEC_W-1:128] == '0);
  assert_zero_word_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && esize[1] && ctrl[31:0] == 32'd0) |=> result[31:0] == 32'd0);
  assert_pass_word_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && esize[1] && !ctrl[31] && ctrl[31:0] != 32'd0) |=>
      result[31:0] == $past(dest[31:0]));
endmodule

bind sgn_apply_top sgn_apply_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sgn_apply_top_tb.sv
module sgn_apply_top_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   mode;
  logic [1:0]   esize;
  logic         len_wide;
  logic [255:0] dest, ctrl, prev_dest;
  logic         out_valid;
  logic [255:0] result;
  logic         ud_err;

  int total = 0;
  int bad   = 0;
  logic [255:0] held;

  always #10 clk = ~clk;

  sgn_apply_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .esize(esize),
    .len_wide(len_wide), .dest(dest), .ctrl(ctrl), .prev_dest(prev_dest),
    .out_valid(out_valid), .result(result), .ud_err(ud_err)
  );

  function automatic logic [255:0] model(logic [1:0] m, logic [1:0] es,
                                         logic [255:0] d, logic [255:0] c,
                                         logic [255:0] p);
    int lw;
    logic [255:0] o;
    lw = (es == 2'd0) ? 8 : (es == 2'd1) ? 16 : 32;
    o  = '0;
    for (int b = 0; b < 256; b += lw) begin
      logic [31:0] msk, dl, cl, rl;
      msk = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 32'd1);
      dl  = 32'(d >> b) & msk;
      cl  = 32'(c >> b) & msk;
      if (cl[lw-1])      rl = (~dl + 32'd1) & msk;
      else if (cl == 0)  rl = 32'd0;
      else               rl = dl;
      o = o | (256'(rl) << b);
    end
    case (m)
      2'd0:    o = {p[255:64], o[63:0]};
      2'd1:    o = {p[255:128], o[127:0]};
      2'd2:    o = {128'd0, o[127:0]};
      default: o = o;
    endcase
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd_vec();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] biased_vec();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) begin
      if ($urandom % 4 == 0) v[w*32 +: 32] = 32'd0;
      else begin
        for (int k = 0; k < 4; k++) begin
          case ($urandom % 4)
            0: v[w*32 + k*8 +: 8] = 8'h00;
            1: v[w*32 + k*8 +: 8] = 8'h80;
            2: v[w*32 + k*8 +: 8] = 8'hFF;
            default: v[w*32 + k*8 +: 8] = 8'($urandom);
          endcase
        end
      end
    end
    return v;
  endfunction

  // Drive at a falling edge, check at the next falling edge.
  task automatic op(input logic [1:0] m, input logic [1:0] es, input logic lwide,
                    input logic [255:0] d, input logic [255:0] c,
                    input logic [255:0] p, input string req);
    logic [255:0] exp;
    logic         illegal;
    illegal  = lwide && (m != 2'd3);
    exp      = illegal ? held : model(m, es, d, c, p);
    in_valid = 1'b1; mode = m; esize = es; len_wide = lwide;
    dest = d; ctrl = c; prev_dest = p;
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 out_valid", {255'd0, out_valid}, 256'd1);
    chk(ud_err == illegal, "R9 ud_err", {255'd0, ud_err}, {255'd0, illegal});
    chk(result == exp, req, result, exp);
    held = exp;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    dest = rnd_vec(); ctrl = rnd_vec(); prev_dest = rnd_vec();
    @(negedge clk);
    chk(!out_valid && !ud_err, "R10 idle flags", {254'd0, out_valid, ud_err}, 256'd0);
    chk(result == held, "R10 idle hold", result, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; mode = 2'd0; esize = 2'd0; len_wide = 1'b0;
    dest = '0; ctrl = '0; prev_dest = '0;
    held = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!out_valid && !ud_err && result == '0, "R11 reset state",
        result, 256'd0);

    // R1: negation wraps on the minimum value, byte and word lanes
    op(2'd3, 2'd0, 1'b0, {32{8'h80}}, {32{8'hFF}}, '0, "R1 byte min wrap");
    op(2'd3, 2'd2, 1'b0, {8{32'h8000_0000}}, {8{32'h8000_0001}}, '0, "R1 word min wrap");
    op(2'd3, 2'd0, 1'b0, {32{8'h05}}, {32{8'h80}}, '0, "R1 byte negate");
    // R2: zero control wipes any value
    op(2'd3, 2'd1, 1'b0, rnd_vec(), '0, rnd_vec(), "R2 zero control");
    // R3: positive control passes
    op(2'd3, 2'd2, 1'b0, rnd_vec(), {8{32'h0000_0001}}, '0, "R3 pass");
    // R4: size 3 acts as 32-bit; byte vs half differ on same data
    op(2'd3, 2'd3, 1'b0, {8{32'h1234_5678}}, {8{32'h0000_FF00}}, '0, "R4 size3 word");
    op(2'd3, 2'd1, 1'b0, {8{32'h1234_5678}}, {8{32'h0001_FF00}}, '0, "R4 half lanes");
    // R5-R8 modes
    op(2'd0, 2'd0, 1'b0, rnd_vec(), biased_vec(), rnd_vec(), "R5 mode64");
    op(2'd1, 2'd1, 1'b0, rnd_vec(), biased_vec(), rnd_vec(), "R6 keep128");
    op(2'd2, 2'd2, 1'b0, rnd_vec(), biased_vec(), rnd_vec(), "R7 clear128");
    op(2'd3, 2'd0, 1'b0, rnd_vec(), biased_vec(), rnd_vec(), "R8 full256");
    // R9: illegal length leaves result held; flag ignored in 256 mode
    op(2'd1, 2'd0, 1'b1, rnd_vec(), rnd_vec(), rnd_vec(), "R9 illegal hold");
    op(2'd0, 2'd2, 1'b1, rnd_vec(), rnd_vec(), rnd_vec(), "R9 illegal hold 64");
    op(2'd3, 2'd1, 1'b1, rnd_vec(), biased_vec(), rnd_vec(), "R9 wide ok in 256");
    // R10: idle keeps result
    idle();
    idle();

    for (int i = 0; i < 600; i++) begin
      logic [255:0] d;
      logic [1:0]   m;
      m = 2'($urandom);
      d = ($urandom % 3 == 0) ? biased_vec() : rnd_vec();
      if ($urandom % 8 == 0) idle();
      case (m)
        2'd0: op(m, 2'($urandom), ($urandom % 10 == 0), d, biased_vec(), rnd_vec(), "R5 random");
        2'd1: op(m, 2'($urandom), ($urandom % 10 == 0), d, biased_vec(), rnd_vec(), "R6 random");
        2'd2: op(m, 2'($urandom), ($urandom % 10 == 0), d, biased_vec(), rnd_vec(), "R7 random");
        default: op(m, 2'($urandom), 1'($urandom), d, biased_vec(), rnd_vec(), "R8 random");
      endcase
    end
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule